// File: doc/BRIEF.md
# I2C Target with Atomic 16-bit Register Reads

This block is an I2C target that gives a bus master access to a bank of 16-bit registers. It takes an 8-bit register pointer. A write transaction carries the target's address with the direction bit clear, then the pointer byte, and optionally a high data byte and a low data byte. After the low byte the block issues one write strobe to the register bank.

A read starts with a repeated START, or a fresh START, and the target address with the direction bit set. While the target acknowledges that address, the block copies the addressed register into a holding buffer. It then shifts the held value out, high byte first. If the master keeps acknowledging, the next two bytes are the bitwise inverse of the same value, so the master can compare them. Later bytes repeat the same four-byte cycle. Changes to the register bank after the snapshot do not show up until the next address phase.

SCL and SDA are sampled by the system clock through a synchronizer. SDA is driven open-drain: the target only pulls it low through `sdaOe`. The pointer is never incremented. It keeps its value between transactions, so a read can reuse the pointer written earlier.

Top module: `i2cSnapTarget`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `devAddr` by driving SDA low during the ninth clock. When the address does not match, it leaves SDA released for that byte and every later bit until the next START.
- R2: A write with the direction bit (bit 0 of the address byte) at 0 has the following order: pointer byte, then high data byte, then low data byte. Each byte is acknowledged. After the low byte's acknowledge, `regWrEn` pulses for exactly one clock, with `regAddr` equal to the pointer and `regWrData` equal to {high byte, low byte}.
- R3: The pointer keeps its last written value across STOP and START. A read issued with only a START and the read address returns the register at that pointer. The same holds for a read that follows a write's low byte with a repeated START.
- R4: The register is captured at the acknowledge of a read address. Changes to `regRdData` after that point do not alter the bytes returned in that transaction.
- R5: Read data is sent high byte first, then low byte, each most significant bit first.
- R6: While the master keeps acknowledging, the bytes after the low byte are the inverse of the high byte, then the inverse of the low byte. The sequence then repeats: high, low, inverse high, inverse low, all from the same snapshot.
- R7: A master NACK after any read byte ends the read. The target releases SDA and ignores further clocks until the next START.
- R8: A START or STOP at any bit position abandons the byte in progress, with no write strobe. A STOP releases SDA. Reset leaves SDA released, `regWrEn` low and the pointer at 0.
- R9: No byte of a read or write changes the pointer except the pointer byte of a write.
- R10: The target changes the level it drives on SDA only while SCL is low.
- R11: A data byte sent after the low byte of a write is not acknowledged and causes no further write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaOe | output | 1 | When 1, pull SDA low |
| devAddr | input | 7 | Target address |
| regRdData | input | 16 | Register bank read data at `regAddr` |
| regAddr | output | 8 | Register pointer |
| regWrData | output | 16 | Value to write |
| regWrEn | output | 1 | One-clock write strobe |

## Verification
The bench changes the addressed register right after the read address is acknowledged. A design that samples late, or samples each byte separately, returns the new value or a torn mix of the two. It reads six bytes in one transaction to catch a complement sequence that inverts the wrong byte, or one that restarts from a fresh sample. It sends a fourth write data byte and cuts a data byte short with a repeated START. A design with loose byte counting would then acknowledge the extra byte, strobe twice or strobe on a partial byte. It also sends a wrong address and a NACK on the first read byte. A target that fails to go quiet would pull SDA low during later bits.

// File: rtl/i2cSnapPkg.sv
package i2cSnapPkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_SACK, PH_TX, PH_MACK
  } phase_e;

  localparam logic [2:0] IDX_ADDR  = 3'd0;
  localparam logic [2:0] IDX_PTR   = 3'd1;
  localparam logic [2:0] IDX_MSB   = 3'd2;
  localparam logic [2:0] IDX_LSB   = 3'd3;
  localparam logic [2:0] IDX_EXTRA = 3'd4;

  typedef struct packed {
    logic             shiftIn;
    logic             loadPtr;
    logic             loadMsb;
    logic             wrFire;
    logic             capture;
    logic             driveAck;
    logic             driveTx;
    logic             relSda;
    logic [BIT_W-1:0] txBit;
    logic [1:0]       rdSel;
  } strobes_t;
endpackage

// File: rtl/i2cSnapSync.sv
module i2cSnapSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[0] <= RESET_VAL;
        else       pipe[0] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[i] <= RESET_VAL;
        else       pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cSnapDatapath.sv
module i2cSnapDatapath
  import i2cSnapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-2:0] devAddr,
  input  logic [REG_W-1:0]  regRdData,
  input  strobes_t          stb,
  output logic              sclLevel,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic              addrMatch,
  output logic              rxRead,
  output logic [BYTE_W-1:0] regAddr,
  output logic [REG_W-1:0]  regWrData,
  output logic              regWrEn,
  output logic              sdaOe
);
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] shiftQ, ptrQ, msbQ, txByte;
  logic [REG_W-1:0]  holdQ, wrDataQ;
  logic              wrEnQ, oeQ;

  i2cSnapSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  i2cSnapSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  assign sclLevel = sclS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sdaBit   = sdaS;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) shiftQ <= '0;
    else if (stb.shiftIn) shiftQ <= {shiftQ[BYTE_W-2:0], sdaS};

  assign addrMatch = (shiftQ[BYTE_W-1:1] == devAddr);
  assign rxRead    = shiftQ[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ptrQ  <= '0;
      msbQ  <= '0;
      holdQ <= '0;
    end else begin
      if (stb.loadPtr) ptrQ  <= shiftQ;
      if (stb.loadMsb) msbQ  <= shiftQ;
      if (stb.capture) holdQ <= regRdData;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= stb.wrFire;
      if (stb.wrFire) wrDataQ <= {msbQ, shiftQ};
    end

  always_comb
    unique case (stb.rdSel)
      2'd0: txByte = holdQ[REG_W-1:BYTE_W];
      2'd1: txByte = holdQ[BYTE_W-1:0];
      2'd2: txByte = ~holdQ[REG_W-1:BYTE_W];
      default: txByte = ~holdQ[BYTE_W-1:0];
    endcase

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) oeQ <= 1'b0;
    else if (stb.driveTx)  oeQ <= ~txByte[BIT_W'(BYTE_W-1) - stb.txBit];
    else if (stb.driveAck) oeQ <= 1'b1;
    else if (stb.relSda)   oeQ <= 1'b0;

  assign regAddr   = ptrQ;
  assign regWrData = wrDataQ;
  assign regWrEn   = wrEnQ;
  assign sdaOe     = oeQ;
endmodule

// File: rtl/i2cSnapControl.sv
module i2cSnapControl
  import i2cSnapPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     startDet,
  input  logic     stopDet,
  input  logic     sdaBit,
  input  logic     addrMatch,
  input  logic     rxRead,
  output strobes_t stb,
  output logic     ctrlIdle
);
  localparam logic [BIT_W:0] BITS_DONE = (BIT_W+1)'(BYTE_W);

  phase_e        phase, phaseN;
  logic [BIT_W:0] bitCnt, bitCntN;
  logic [2:0]    byteIdx, byteIdxN;
  logic          isRead, isReadN;
  logic [1:0]    rdIdx, rdIdxN;
  logic          mAcked, mAckedN;

  always_comb begin
    stb       = '0;
    stb.txBit = bitCnt[BIT_W-1:0];
    stb.rdSel = rdIdx;
    phaseN    = phase;
    bitCntN   = bitCnt;
    byteIdxN  = byteIdx;
    isReadN   = isRead;
    rdIdxN    = rdIdx;
    mAckedN   = mAcked;

    if (startDet) begin
      phaseN     = PH_RX;
      bitCntN    = '0;
      byteIdxN   = IDX_ADDR;
      stb.relSda = 1'b1;
    end else if (stopDet) begin
      phaseN     = PH_IDLE;
      stb.relSda = 1'b1;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (sclRise && bitCnt != BITS_DONE) begin
            stb.shiftIn = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BITS_DONE) begin
            unique case (byteIdx)
              IDX_ADDR: begin
                if (addrMatch) begin
                  stb.driveAck = 1'b1;
                  stb.capture  = rxRead;
                  isReadN      = rxRead;
                  rdIdxN       = 2'd0;
                  phaseN       = PH_SACK;
                end else begin
                  phaseN = PH_IDLE;
                end
              end
              IDX_PTR: begin
                stb.loadPtr  = 1'b1;
                stb.driveAck = 1'b1;
                phaseN       = PH_SACK;
              end
              IDX_MSB: begin
                stb.loadMsb  = 1'b1;
                stb.driveAck = 1'b1;
                phaseN       = PH_SACK;
              end
              IDX_LSB: begin
                stb.driveAck = 1'b1;
                phaseN       = PH_SACK;
              end
              default: phaseN = PH_IDLE;
            endcase
          end
        end
        PH_SACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (isRead) begin
              stb.driveTx = 1'b1;
              stb.txBit   = '0;
              phaseN      = PH_TX;
            end else begin
              stb.relSda = 1'b1;
              stb.wrFire = (byteIdx == IDX_LSB);
              byteIdxN   = (byteIdx == IDX_EXTRA) ? IDX_EXTRA : byteIdx + 1'b1;
              phaseN     = PH_RX;
            end
          end
        end
        PH_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt != BITS_DONE) begin
              stb.driveTx = 1'b1;
            end else begin
              stb.relSda = 1'b1;
              mAckedN    = 1'b0;
              phaseN     = PH_MACK;
            end
          end
        end
        PH_MACK: begin
          if (sclRise) begin
            if (sdaBit) phaseN  = PH_IDLE;
            else        mAckedN = 1'b1;
          end else if (sclFall && mAcked) begin
            rdIdxN      = rdIdx + 1'b1;
            stb.rdSel   = rdIdx + 1'b1;
            stb.txBit   = '0;
            stb.driveTx = 1'b1;
            bitCntN     = '0;
            phaseN      = PH_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      byteIdx <= IDX_ADDR;
      isRead  <= 1'b0;
      rdIdx   <= '0;
      mAcked  <= 1'b0;
    end else begin
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      byteIdx <= byteIdxN;
      isRead  <= isReadN;
      rdIdx   <= rdIdxN;
      mAcked  <= mAckedN;
    end

  assign ctrlIdle = (phase == PH_IDLE);
endmodule

// File: rtl/i2cSnapTarget.sv
module i2cSnapTarget
  import i2cSnapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [BYTE_W-2:0] devAddr,
  input  logic [REG_W-1:0]  regRdData,
  output logic [BYTE_W-1:0] regAddr,
  output logic [REG_W-1:0]  regWrData,
  output logic              regWrEn
);
  strobes_t stb;
  logic sclLevel, sclRise, sclFall, startDet, stopDet, sdaBit;
  logic addrMatch, rxRead, ctrlIdle;

  i2cSnapDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(devAddr), .regRdData(regRdData), .stb(stb),
    .sclLevel(sclLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rxRead(rxRead), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .sdaOe(sdaOe));

  i2cSnapControl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .addrMatch(addrMatch), .rxRead(rxRead), .stb(stb),
    .ctrlIdle(ctrlIdle));
endmodule

// File: rtl/i2cSnapChecker.sv
module i2cSnapChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclLevel,
  input logic       startDet,
  input logic       stopDet,
  input logic       ctrlIdle,
  input logic       sdaOe,
  input logic       regWrEn,
  input logic [7:0] regAddr
);
  // R10
  sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLevel);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIdle && $past(ctrlIdle)) |-> !sdaOe);

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R9
  ptr_hold_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $stable(regAddr));
endmodule

bind i2cSnapTarget i2cSnapChecker u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .startDet(startDet),
  .stopDet(stopDet), .ctrlIdle(ctrlIdle), .sdaOe(sdaOe),
  .regWrEn(regWrEn), .regAddr(regAddr));

// File: tb/i2cSnapTarget_bench.sv
module i2cSnapTarget_bench;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regWrEn;
  logic [7:0]  regAddr;
  logic [15:0] regWrData, regRdData;
  logic [15:0] bank [256];
  wire sdaLine = sdaM & ~sdaOe;

  int vecCnt = 0, errCnt = 0, wrCount = 0;
  bit done = 1'b0;
  logic [23:0] expQ [$];

  always #2.5 clk = ~clk;

  assign regRdData = bank[regAddr];

  i2cSnapTarget u_i2cSnapTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .devAddr(DEV), .regRdData(regRdData), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn));

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design strobes them
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      wrCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected write", {regAddr, regWrData}, 24'h0);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check({regAddr, regWrData} == e, "R2 write", {regAddr, regWrData}, e);
      end
      bank[regAddr] = regWrData;
    end
  end

  task automatic tick(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1; tick(); sclM = 1; tick(); sdaM = 0; tick(); sclM = 0; tick();
  endtask

  task automatic busStop();
    sdaM = 0; tick(); sclM = 1; tick(); sdaM = 1; tick();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; tick(); sclM = 1; tick(); tick(); sclM = 0; tick();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1; tick(); sclM = 1; tick(); b = sdaLine; tick(); sclM = 0; tick();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      getBit(b);
      v[i] = b;
    end
    putBit(~mAck);
  endtask

  task automatic writeReg(input logic [7:0] ptr, input logic [15:0] val);
    logic a;
    expQ.push_back({ptr, val});
    busStart();
    sendByte({DEV, 1'b0}, a); check(a, "R1 addr ack", 24'(a), 24'h1);
    sendByte(ptr, a);         check(a, "R2 ptr ack", 24'(a), 24'h1);
    sendByte(val[15:8], a);   check(a, "R2 msb ack", 24'(a), 24'h1);
    sendByte(val[7:0], a);    check(a, "R2 lsb ack", 24'(a), 24'h1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errCnt++; vecCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin : stimulus
    logic a;
    logic [7:0] v;
    logic [15:0] snap;
    int wrBefore;
    for (int i = 0; i < 256; i++) bank[i] = 16'(i * 257) ^ 16'h5A3C;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R8 reset state
    check(!sdaOe && !regWrEn && regAddr == 8'h00, "R8 reset",
          {regAddr, 7'h0, sdaOe, 7'h0, regWrEn}, 24'h0);

    // R2 write
    writeReg(8'h12, 16'hBEEF);
    busStop();
    tick();
    check(wrCount == 1, "R2 one strobe", 24'(wrCount), 24'd1);

    // R5 read with pointer reload
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h12, a);
    busStart();
    sendByte({DEV, 1'b1}, a); check(a, "R1 read addr ack", 24'(a), 24'h1);
    recvByte(1'b1, v); check(v == 8'hBE, "R5 msb", 24'(v), 24'hBE);
    recvByte(1'b0, v); check(v == 8'hEF, "R5 lsb", 24'(v), 24'hEF);
    busStop();
    check(regAddr == 8'h12, "R9 ptr unchanged", 24'(regAddr), 24'h12);

    // R3 read reusing stored pointer; R6 complement cycle
    busStart();
    sendByte({DEV, 1'b1}, a);
    snap = bank[8'h12];
    recvByte(1'b1, v); check(v == snap[15:8], "R3 msb", 24'(v), 24'(snap[15:8]));
    recvByte(1'b1, v); check(v == snap[7:0], "R3 lsb", 24'(v), 24'(snap[7:0]));
    recvByte(1'b1, v); check(v == ~snap[15:8], "R6 ~msb", 24'(v), 24'(~snap[15:8]));
    recvByte(1'b1, v); check(v == ~snap[7:0], "R6 ~lsb", 24'(v), 24'(~snap[7:0]));
    recvByte(1'b1, v); check(v == snap[15:8], "R6 repeat msb", 24'(v), 24'(snap[15:8]));
    recvByte(1'b0, v); check(v == snap[7:0], "R6 repeat lsb", 24'(v), 24'(snap[7:0]));
    busStop();

    // R4 snapshot at address ack
    busStart();
    sendByte({DEV, 1'b1}, a);
    bank[8'h12] = 16'h1234;
    recvByte(1'b1, v); check(v == 8'hBE, "R4 held msb", 24'(v), 24'hBE);
    recvByte(1'b0, v); check(v == 8'hEF, "R4 held lsb", 24'(v), 24'hEF);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b1, v); check(v == 8'h12, "R4 new sample msb", 24'(v), 24'h12);
    recvByte(1'b0, v); check(v == 8'h34, "R4 new sample lsb", 24'(v), 24'h34);
    busStop();

    // R1 mismatched address
    wrBefore = wrCount;
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a); check(!a, "R1 no ack on mismatch", 24'(a), 24'h0);
    sendByte(8'h77, a);               check(!a, "R1 silent after mismatch", 24'(a), 24'h0);
    busStop();
    check(regAddr == 8'h12, "R1 ptr untouched", 24'(regAddr), 24'h12);

    // R3 write then repeated START read without pointer
    writeReg(8'h20, 16'hA55A);
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b1, v); check(v == 8'hA5, "R3 sr msb", 24'(v), 24'hA5);
    recvByte(1'b0, v); check(v == 8'h5A, "R3 sr lsb", 24'(v), 24'h5A);
    busStop();

    // R11 extra write byte
    wrBefore = wrCount;
    writeReg(8'h40, 16'h1122);
    sendByte(8'h33, a); check(!a, "R11 extra byte nack", 24'(a), 24'h0);
    busStop();
    tick();
    check(wrCount == wrBefore + 1, "R11 single strobe", 24'(wrCount), 24'(wrBefore + 1));

    // R8 abort a data byte with a repeated START
    wrBefore = wrCount;
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h50, a);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStart();
    sendByte({DEV, 1'b1}, a);
    snap = bank[8'h50];
    recvByte(1'b1, v); check(v == snap[15:8], "R8 abort msb", 24'(v), 24'(snap[15:8]));
    recvByte(1'b0, v); check(v == snap[7:0], "R8 abort lsb", 24'(v), 24'(snap[7:0]));
    busStop();
    check(wrCount == wrBefore, "R8 no write on abort", 24'(wrCount), 24'(wrBefore));
    check(!sdaOe, "R8 released after stop", 24'(sdaOe), 24'h0);

    // R7 NACK on first read byte
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b0, v); check(v == snap[15:8], "R7 msb before nack", 24'(v), 24'(snap[15:8]));
    recvByte(1'b1, v); check(v == 8'hFF, "R7 quiet after nack", 24'(v), 24'hFF);
    busStop();

    tick();
    check(expQ.size() == 0, "R2 all writes seen", 24'(expQ.size()), 24'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule